// File: doc/BRIEF.md
# Extended-to-Single Rounding Packer

This block converts one internal extended-format value into a 32-bit IEEE single-precision word. The value arrives as a sign, an unbiased signed exponent, a 64-bit significand with an explicit integer bit at position 63, and a three-bit class code. The class code distinguishes a finite value, zero, infinity, NaN and an empty source. The block applies one of four rounding modes. It moves values that fall below the normal range into denormal position. It returns the packed word together with a write-enable and the exception flags that the conversion raised.

The conversion is computed combinationally. Its result is captured in one output register stage, so every input strobe is answered exactly one cycle later by a single-cycle `out_valid`. Four mask inputs decide whether a raised exception still lets the word be written. A store unit uses `out_we` to commit the word, and it merges the flags into its own status.

Top module: `ext_to_single_pack`

## Requirements
- R1: After reset, `out_valid` and `out_we` are low. Each cycle with `in_valid` high produces `out_valid` high in the next cycle, and `out_valid` is low after any cycle without `in_valid`. `out_we` is never high without `out_valid`.
- R2: A finite value with exponent in [-126, 127] that needs no rounding is packed with the sign in bit 31, `in_exp + 127` in bits 30:23, and significand bits 62:40 in bits 22:0. It is written with no flags raised.
- R3: In round-to-nearest (`rnd_mode` = 0), the 24 retained bits are 63:40, and bit 39 is the half position. The result is incremented when the discarded bits 39:0 exceed half. It is also incremented on an exact half when the retained least significant bit is 1.
- R4: Round-down (`rnd_mode` = 1) increments only negative values with a nonzero discarded part. Round-up (`rnd_mode` = 2) increments only positive values with a nonzero discarded part. Truncate (`rnd_mode` = 3) never increments.
- R5: A nonzero discarded part raises `flag_prec`. `flag_up` is high exactly when the result was incremented. In the normal range, an inexact result is written whatever the precision mask is.
- R6: An increment that carries out of the 24 retained bits gives a significand of 1.0 and raises the exponent by one.
- R7: A rounded exponent above 127 raises `flag_ovf`, `flag_prec` and `flag_up`. The word is signed infinity (exponent 0xFF, fraction 0) and is written only when both the overflow mask and the precision mask are set.
- R8: A finite value with exponent below -126 is shifted into denormal position, with a least significant fraction bit of weight 2^-149, and then rounded by the same mode rules. A rounded result of 0x800000 becomes the smallest normal number. An inexact denormal result raises `flag_unf` and `flag_prec`, and it is written only when both the underflow mask and the precision mask are set. An exact one raises nothing.
- R9: Class 1 (zero) gives signed zero, and class 2 (infinity) gives signed 0x7F800000. Both are written with no flags.
- R10: Class 3 (NaN) gives exponent 0xFF and fraction from significand bits 62:40. When bit 62 is clear, `flag_inv` is raised, fraction bit 22 is set, and the word is written only when the invalid mask is set.
- R11: Class 4 (empty), and the unused codes 5 to 7, raise `flag_stk` and `flag_inv`. The word 0xFFC00000 is written when the invalid mask is set. Otherwise nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input strobe |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_sig | input | 64 | Significand, integer bit at 63 |
| in_class | input | 3 | 0 finite, 1 zero, 2 infinity, 3 NaN, 4-7 empty |
| rnd_mode | input | 2 | 0 nearest-even, 1 down, 2 up, 3 truncate |
| msk_invalid | input | 1 | Invalid (and stack fault) masked |
| msk_overflow | input | 1 | Overflow masked |
| msk_underflow | input | 1 | Underflow masked |
| msk_precision | input | 1 | Precision masked |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_we | output | 1 | Write the packed word |
| out_word | output | 32 | Packed single-precision word |
| flag_inv | output | 1 | Invalid raised |
| flag_stk | output | 1 | Stack underflow raised |
| flag_ovf | output | 1 | Overflow raised |
| flag_unf | output | 1 | Underflow raised |
| flag_prec | output | 1 | Precision raised |
| flag_up | output | 1 | Precision result was rounded up |

## Verification
The assertions assume that a finite input is normalised, with bit 63 of the significand set, and that its exponent is small enough for the widened arithmetic not to wrap. The stimulus holds to this: every finite vector has bit 63 set and an exponent between -300 and 200. Empty and infinity checks rely only on the class code and the invalid mask, so they hold for any significand. The stimulus drives exact ties and carry chains of all ones, and it places exponents at both edges of the normal range. Every mask is cleared one at a time on the paths that depend on it.

// File: rtl/ext_to_single_pack.sv
module ext_to_single_pack #(
  parameter int EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [63:0]      in_sig,
  input  logic [2:0]       in_class,
  input  logic [1:0]       rnd_mode,
  input  logic             msk_invalid,
  input  logic             msk_overflow,
  input  logic             msk_underflow,
  input  logic             msk_precision,
  output logic             out_valid,
  output logic             out_we,
  output logic [31:0]      out_word,
  output logic             flag_inv,
  output logic             flag_stk,
  output logic             flag_ovf,
  output logic             flag_unf,
  output logic             flag_prec,
  output logic             flag_up
);
  localparam int EW = EXP_W + 2;
  localparam logic signed [EW-1:0] MIN_E   = -126;
  localparam logic signed [EW-1:0] MAX_E   = 127;
  localparam logic signed [EW-1:0] DEN_OFF = -86;
  localparam logic signed [EW-1:0] SH_MAX  = 127;
  localparam logic [2:0] CL_FIN = 3'd0, CL_ZERO = 3'd1, CL_INF = 3'd2, CL_NAN = 3'd3;

  function automatic logic inc_rule(input logic [1:0] m, input logic s,
                                    input logic lsb, input logic half, input logic rest);
    case (m)
      2'd0:    return half & (rest | lsb);
      2'd1:    return s & (half | rest);
      2'd2:    return ~s & (half | rest);
      default: return 1'b0;
    endcase
  endfunction

  logic signed [EW-1:0] e, n_exp, dsh_raw, biased;
  assign e = {{2{in_exp[EXP_W-1]}}, in_exp};

  // normal range: keep 63:40
  logic [23:0] n_kept;
  logic [24:0] n_sum;
  logic [23:0] n_mant;
  logic        n_inc, n_inexact, n_ovf;
  assign n_kept    = in_sig[63:40];
  assign n_inexact = |in_sig[39:0];
  assign n_inc     = inc_rule(rnd_mode, in_sign, n_kept[0], in_sig[39], |in_sig[38:0]);
  assign n_sum     = {1'b0, n_kept} + 25'(n_inc);
  assign n_mant    = n_sum[24] ? 24'h800000 : n_sum[23:0];
  assign n_exp     = e + EW'(n_sum[24]);
  assign n_ovf     = n_exp > MAX_E;
  assign biased    = n_exp + MAX_E;

  // below normal range: align to weight 2^-149
  logic         tiny, d_inc, d_inexact;
  logic [6:0]   dsh;
  logic [127:0] ext;
  logic [23:0]  d_sum;
  assign tiny      = e < MIN_E;
  assign dsh_raw   = DEN_OFF - e;
  assign dsh       = (dsh_raw > SH_MAX) ? 7'd127 : dsh_raw[6:0];
  assign ext       = {in_sig, 64'd0} >> dsh;
  assign d_inexact = |ext[63:0];
  assign d_inc     = inc_rule(rnd_mode, in_sign, ext[64], ext[63], |ext[62:0]);
  assign d_sum     = {1'b0, ext[86:64]} + 24'(d_inc);

  logic        we_c, inv_c, stk_c, ovf_c, unf_c, prec_c, up_c;
  logic [31:0] word_c;

  always_comb begin
    we_c = 1'b1; word_c = 32'd0;
    inv_c = 1'b0; stk_c = 1'b0; ovf_c = 1'b0; unf_c = 1'b0; prec_c = 1'b0; up_c = 1'b0;
    case (in_class)
      CL_FIN: begin
        if (tiny) begin
          word_c = {in_sign, 7'd0, d_sum};
          if (d_inexact) begin
            unf_c = 1'b1; prec_c = 1'b1; up_c = d_inc;
            we_c  = msk_underflow & msk_precision;
          end
        end else if (n_ovf) begin
          ovf_c = 1'b1; prec_c = 1'b1; up_c = 1'b1;
          we_c   = msk_overflow & msk_precision;
          word_c = {in_sign, 31'h7F800000};
        end else begin
          prec_c = n_inexact; up_c = n_inc;
          word_c = {in_sign, biased[7:0], n_mant[22:0]};
        end
      end
      CL_ZERO: word_c = {in_sign, 31'd0};
      CL_INF:  word_c = {in_sign, 31'h7F800000};
      CL_NAN: begin
        word_c = {in_sign, 8'hFF, in_sig[62:40]};
        if (!in_sig[62]) begin
          inv_c = 1'b1; we_c = msk_invalid; word_c[22] = 1'b1;
        end
      end
      default: begin
        stk_c = 1'b1; inv_c = 1'b1; we_c = msk_invalid;
        word_c = 32'hFFC00000;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_we <= 1'b0; out_word <= 32'd0;
      {flag_inv, flag_stk, flag_ovf, flag_unf, flag_prec, flag_up} <= 6'd0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid & we_c;
      if (in_valid) out_word <= word_c;
      {flag_inv, flag_stk, flag_ovf, flag_unf, flag_prec, flag_up} <=
        {6{in_valid}} & {inv_c, stk_c, ovf_c, unf_c, prec_c, up_c};
    end
  end
endmodule

module ext_to_single_pack_chk #(
  parameter int EXP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       in_class,
  input logic             msk_invalid,
  input logic             out_valid,
  input logic             out_we,
  input logic [31:0]      out_word,
  input logic             flag_inv,
  input logic             flag_stk,
  input logic             flag_ovf,
  input logic             flag_unf,
  input logic             flag_prec,
  input logic             flag_up
);
  assert_we_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_up_implies_prec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_up |-> flag_prec);
  assert_ovf_is_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && flag_ovf) |-> (out_word[30:0] == 31'h7F800000));
  assert_unf_small_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && flag_unf) |-> (out_word[30:23] <= 8'd1));
  assert_inf_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd2) |=> (out_we && out_word[30:0] == 31'h7F800000));
  assert_empty_indef_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class >= 3'd4 && msk_invalid) |=>
      (out_we && out_word == 32'hFFC00000 && flag_stk && flag_inv));
  assert_stk_is_invalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_stk |-> flag_inv);
  assert_no_ovf_unf_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_ovf && flag_unf));
endmodule

bind ext_to_single_pack ext_to_single_pack_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
  .msk_invalid(msk_invalid), .out_valid(out_valid), .out_we(out_we),
  .out_word(out_word), .flag_inv(flag_inv), .flag_stk(flag_stk),
  .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_prec(flag_prec), .flag_up(flag_up)
);

// File: tb/ext_to_single_pack_bench.sv
`timescale 1ns/1ps
module ext_to_single_pack_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0;
  logic [15:0] in_exp = '0;
  logic [63:0] in_sig = '0;
  logic [2:0]  in_class = '0;
  logic [1:0]  rnd_mode = '0;
  logic        msk_invalid = 1'b1, msk_overflow = 1'b1, msk_underflow = 1'b1, msk_precision = 1'b1;
  logic        out_valid, out_we, flag_inv, flag_stk, flag_ovf, flag_unf, flag_prec, flag_up;
  logic [31:0] out_word;

  ext_to_single_pack u_ext_to_single_pack (.*);

  always #2 clk = ~clk;

  logic [38:0] exp_q[$];
  string       tag_q[$];
  int vectors = 0, fails = 0, checks = 0;
  bit done = 1'b0;

  localparam logic [3:0] ALL = 4'hF;

  // masks: {invalid, overflow, underflow, precision}; flags: {inv,stk,ovf,unf,prec,up}
  task automatic send(input bit s, input int ex, input logic [63:0] sg, input logic [2:0] cl,
                      input logic [1:0] md, input logic [3:0] mk,
                      input bit we, input logic [31:0] w, input logic [5:0] fl, input string tag);
    @(negedge clk);
    in_sign = s; in_exp = 16'(ex); in_sig = sg; in_class = cl; rnd_mode = md;
    {msk_invalid, msk_overflow, msk_underflow, msk_precision} = mk;
    in_valid = 1'b1;
    exp_q.push_back({we, w, fl});
    tag_q.push_back(tag);
    vectors++;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && out_valid) begin
        logic [38:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          fails++; $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          if (out_we !== e[38] || (e[38] && out_word !== e[37:6]) ||
              {flag_inv, flag_stk, flag_ovf, flag_unf, flag_prec, flag_up} !== e[5:0]) begin
            fails++;
            $display("FAIL %s: actual we=%b word=%h flags=%b expected we=%b word=%h flags=%b",
                     t, out_we, out_word,
                     {flag_inv, flag_stk, flag_ovf, flag_unf, flag_prec, flag_up},
                     e[38], e[37:6], e[5:0]);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || out_we !== 1'b0) begin
      fails++; $display("FAIL R1 reset: actual valid=%b we=%b expected 0 0", out_valid, out_we);
    end
    @(negedge clk); rst_n = 1'b1;

    send(0, 0,   64'h8000000000000000, 0, 0, ALL, 1, 32'h3F800000, 6'b000000, "R2 one");
    send(1, 1,   64'hC000000000000000, 0, 0, ALL, 1, 32'hC0400000, 6'b000000, "R2 minus three");
    send(0, 127, 64'h8000000000000000, 0, 0, ALL, 1, 32'h7F000000, 6'b000000, "R2 top exponent");
    send(0, -126,64'h8000000000000000, 0, 0, ALL, 1, 32'h00800000, 6'b000000, "R2 bottom exponent");
    send(0, 0,   64'h8000008000000000, 0, 0, ALL, 1, 32'h3F800000, 6'b000010, "R3 tie even stays");
    send(0, 0,   64'h8000018000000000, 0, 0, ALL, 1, 32'h3F800002, 6'b000011, "R3 tie odd rounds up");
    send(0, 0,   64'h8000008000000001, 0, 0, ALL, 1, 32'h3F800001, 6'b000011, "R3 above half");
    send(0, 0,   64'h8000007FFFFFFFFF, 0, 0, ALL, 1, 32'h3F800000, 6'b000010, "R3 below half");
    send(0, 0,   64'h8000000000000001, 0, 1, ALL, 1, 32'h3F800000, 6'b000010, "R4 down positive");
    send(1, 0,   64'h8000000000000001, 0, 1, ALL, 1, 32'hBF800001, 6'b000011, "R4 down negative");
    send(0, 0,   64'h8000000000000001, 0, 2, ALL, 1, 32'h3F800001, 6'b000011, "R4 up positive");
    send(1, 0,   64'h8000000000000001, 0, 2, ALL, 1, 32'hBF800000, 6'b000010, "R4 up negative");
    send(1, 0,   64'h800001FFFFFFFFFF, 0, 3, ALL, 1, 32'hBF800001, 6'b000010, "R4 truncate");
    send(0, 0,   64'h8000018000000000, 0, 0, 4'b1110, 1, 32'h3F800002, 6'b000011, "R5 inexact written unmasked");
    send(0, 0,   64'hFFFFFFFFFFFFFFFF, 0, 0, ALL, 1, 32'h40000000, 6'b000011, "R6 carry out");
    send(0, 127, 64'hFFFFFFFFFFFFFFFF, 0, 0, ALL, 1, 32'h7F800000, 6'b001011, "R7 carry overflow");
    send(1, 200, 64'h8000000000000000, 0, 3, ALL, 1, 32'hFF800000, 6'b001011, "R7 overflow masked");
    send(0, 200, 64'h8000000000000000, 0, 0, 4'b1011, 0, 32'h0, 6'b001011, "R7 overflow unmasked");
    send(0, 200, 64'h8000000000000000, 0, 0, 4'b1110, 0, 32'h0, 6'b001011, "R7 precision unmasked");
    send(0, -127,64'h8000000000000000, 0, 0, ALL, 1, 32'h00400000, 6'b000000, "R8 exact denormal");
    send(0, -127,64'h8000000000000001, 0, 0, ALL, 1, 32'h00400000, 6'b000110, "R8 inexact denormal");
    send(0, -127,64'hFFFFFFFFFFFFFFFF, 0, 0, ALL, 1, 32'h00800000, 6'b000111, "R8 rounds to normal");
    send(0, -127,64'h8000000000000001, 0, 0, 4'b1101, 0, 32'h0, 6'b000110, "R8 underflow unmasked");
    send(1, -300,64'h8000000000000000, 0, 1, ALL, 1, 32'h80000001, 6'b000111, "R8 tiny rounds down");
    send(1, -300,64'h8000000000000000, 0, 0, ALL, 1, 32'h80000000, 6'b000110, "R8 tiny to zero");
    send(1, 5,   64'h0,                1, 0, ALL, 1, 32'h80000000, 6'b000000, "R9 zero");
    send(0, 0,   64'h8000000000000000, 2, 0, ALL, 1, 32'h7F800000, 6'b000000, "R9 infinity");
    send(1, 0,   64'h8000000000000000, 2, 2, ALL, 1, 32'hFF800000, 6'b000000, "R9 neg infinity");
    send(0, 0,   64'hC000010000000000, 3, 0, ALL, 1, 32'h7FC00001, 6'b000000, "R10 quiet NaN");
    send(1, 0,   64'hA000000000000000, 3, 0, ALL, 1, 32'hFFE00000, 6'b100000, "R10 signalling masked");
    send(1, 0,   64'hA000000000000000, 3, 0, 4'b0111, 0, 32'h0, 6'b100000, "R10 signalling unmasked");
    send(0, 0,   64'h0,                4, 0, ALL, 1, 32'hFFC00000, 6'b110000, "R11 empty masked");
    send(0, 0,   64'h0,                4, 0, 4'b0111, 0, 32'h0, 6'b110000, "R11 empty unmasked");
    send(1, 3,   64'h8000000000000000, 7, 0, ALL, 1, 32'hFFC00000, 6'b110000, "R11 unused code");

    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R1 missing results: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule